// File: doc/BRIEF.md
# Interpolating Quarter-Wave Sine Synthesizer

This block is a direct digital synthesis core that emits one signed sine sample per clock for an external DAC. A wide phase register grows by a frequency tuning word on each clock where the enable is high. It wraps silently past its top value, so the output frequency is f_clk × tuning_word / 2^ACC_W.

The top two phase bits pick a quadrant. The next IDX_W-2 bits address a table that holds only the rising quarter of the sine. Odd quadrants read the table backwards and the lower half-cycle negates the result. The FRAC_W phase bits below the table address weight a straight-line blend between two neighbouring entries, which replaces plain phase truncation. A parameter can add a fixed gain of 1/cos(π/2^IDX_W) that lifts the chord back toward the arc near the crest. This gain is off by default.

The datapath has three registered stages: fold, table read, and blend with sign. A valid strobe travels with each sample. Changing the tuning word never resets the phase.

Top module: `sine_dds`

## Requirements
- R1: Synchronous active-high reset clears the phase to zero and drops `sample_vld`. The first valid sample after reset is therefore 0.
- R2: On each clock with `ce` high, the phase grows by `ftw` modulo 2^ACC_W. The k-th valid sample after reset, counting from 0, belongs to phase k·ftw mod 2^32. Tuning words at or above 2^31 wrap and run the sine backwards.
- R3: While `ce` is low the phase holds. Samples after the gap continue from the held phase.
- R4: `sample_vld` after clock edge E equals the value `ce` had at edge E-2, so there are three registered stages. The stage-one capture at edge E-2 is the first of them.
- R5: Every valid sample is within 2 LSB of 32767·sin(2π·p/65536), where p is bits [31:16] of the phase.
- R6: The four quadrant points are exact: phases 0, 2^30, 2^31 and 3·2^30 yield 0, +32767, 0 and -32767.
- R7: A tuning word of 2^32/P makes the sample sequence repeat exactly every P samples.
- R8: A new tuning word applies from the next enabled clock. The phase is kept, so the waveform has no jump.
- R9: Valid samples stay within ±32767 and never take the code -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable: advances the phase and marks a sample |
| ftw | input | ACC_W | Frequency tuning word added per enabled clock |
| sample | output | OUT_W | Signed two's-complement sine sample |
| sample_vld | output | 1 | High when `sample` carries a new value |

## Verification
On every cycle, the bound checker confirms four things. The valid strobe tracks the enable three stages later. Reset drops the strobe, and the first sample after reset is zero. No sample leaves the symmetric full-scale range. The bench's scenarios alone can show numeric accuracy against a real-valued sine, exact quadrant points and exact periodicity. They also show phase continuity across enable gaps and retuning, and the reversed sine of wrapped tuning words. Each of these needs a model of the phase over many samples.

// File: rtl/sdds_pkg.sv
package sdds_pkg;

    // Quadrant code: bit 0 mirrors the table address, bit 1 negates the result.
    typedef enum logic [1:0] {
        QD_POS_RISE = 2'd0,
        QD_POS_FALL = 2'd1,
        QD_NEG_FALL = 2'd2,
        QD_NEG_RISE = 2'd3
    } quad_e;

    localparam real PI_R = 3.14159265358979323846;

    function automatic logic quad_mirror(quad_e q);
        return q[0];
    endfunction

    function automatic logic quad_negate(quad_e q);
        return q[1];
    endfunction

    // Odd power series; accurate to double precision over [0, pi/2].
    function automatic real series_sin(real x);
        real term;
        real total;
        term  = x;
        total = x;
        for (int k = 1; k < 12; k++) begin
            term  = -term * x * x / real'((2 * k) * (2 * k + 1));
            total = total + term;
        end
        return total;
    endfunction

    // Rounded magnitude of table entry k of a quarter wave with qsize steps.
    function automatic int quarter_entry(int k, int qsize, int fs);
        real ang;
        ang = PI_R / 2.0 * real'(k) / real'(qsize);
        return $rtoi(series_sin(ang) * real'(fs) + 0.5);
    endfunction

    // Fixed-point 1/cos(half table step) with gbits fraction bits.
    function automatic int gain_word(int idx_w, int gbits);
        real half_step;
        real c;
        half_step = PI_R / real'(2 ** idx_w);
        c         = series_sin(PI_R / 2.0 - half_step);
        return $rtoi(real'(2 ** gbits) / c + 0.5);
    endfunction

endpackage

// File: rtl/sdds_accum.sv
module sdds_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [ACC_W-1:0] ftw,
    output logic [ACC_W-1:0] phase
);
    always_ff @(posedge clk) begin
        if (rst)     phase <= '0;
        else if (ce) phase <= phase + ftw;
    end
endmodule

// File: rtl/sdds_fold.sv
module sdds_fold
    import sdds_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int IDX_W  = 10,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [ACC_W-1:0]  phase,
    output logic [IDX_W-2:0]  lo_addr,
    output logic [IDX_W-2:0]  hi_addr,
    output logic [FRAC_W-1:0] frac,
    output logic              neg,
    output logic              out_vld
);
    localparam int QA_W = IDX_W - 2;
    localparam logic [QA_W:0] QSZ = (QA_W + 1)'(2 ** QA_W);

    quad_e           qd;
    logic [QA_W:0]   idx_ext;
    logic [QA_W:0]   lo_c;
    logic [QA_W:0]   hi_c;

    always_comb begin
        qd      = quad_e'(phase[ACC_W-1 -: 2]);
        idx_ext = {1'b0, phase[ACC_W-3 -: QA_W]};
        if (quad_mirror(qd)) begin
            lo_c = QSZ - idx_ext;
            hi_c = QSZ - idx_ext - (QA_W + 1)'(1);
        end else begin
            lo_c = idx_ext;
            hi_c = idx_ext + (QA_W + 1)'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_addr <= '0;
            hi_addr <= '0;
            frac    <= '0;
            neg     <= 1'b0;
            out_vld <= 1'b0;
        end else begin
            lo_addr <= lo_c;
            hi_addr <= hi_c;
            frac    <= phase[ACC_W-IDX_W-1 -: FRAC_W];
            neg     <= quad_negate(qd);
            out_vld <= in_vld;
        end
    end
endmodule

// File: rtl/sdds_qtable.sv
module sdds_qtable
    import sdds_pkg::*;
#(
    parameter int QA_W   = 8,
    parameter int AMP_W  = 16,
    parameter int FS     = 32767,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [QA_W:0]     lo_addr,
    input  logic [QA_W:0]     hi_addr,
    input  logic [FRAC_W-1:0] frac_in,
    input  logic              neg_in,
    output logic [AMP_W-1:0]  y_lo,
    output logic [AMP_W-1:0]  y_hi,
    output logic [FRAC_W-1:0] frac_out,
    output logic              neg_out,
    output logic              out_vld
);
    localparam int QSIZE = 2 ** QA_W;

    // Entries 0..QSIZE; the extra last entry is full scale for the crest.
    logic [AMP_W-1:0] rom [0:QSIZE];

    for (genvar k = 0; k <= QSIZE; k++) begin : g_entry
        localparam int VAL = quarter_entry(k, QSIZE, FS);
        assign rom[k] = AMP_W'(VAL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y_lo     <= '0;
            y_hi     <= '0;
            frac_out <= '0;
            neg_out  <= 1'b0;
            out_vld  <= 1'b0;
        end else begin
            y_lo     <= rom[lo_addr];
            y_hi     <= rom[hi_addr];
            frac_out <= frac_in;
            neg_out  <= neg_in;
            out_vld  <= in_vld;
        end
    end
endmodule

// File: rtl/sdds_lerp.sv
module sdds_lerp
    import sdds_pkg::*;
#(
    parameter int AMP_W   = 16,
    parameter int FRAC_W  = 6,
    parameter int OUT_W   = 16,
    parameter int IDX_W   = 10,
    parameter int FS      = 32767,
    parameter bit GAIN_EN = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_vld,
    input  logic [AMP_W-1:0]        y_lo,
    input  logic [AMP_W-1:0]        y_hi,
    input  logic [FRAC_W-1:0]       frac,
    input  logic                    neg,
    output logic signed [OUT_W-1:0] sample,
    output logic                    out_vld
);
    localparam int PW = AMP_W + FRAC_W + 2;
    localparam logic signed [PW-1:0] HALF_LSB = PW'(1) <<< (FRAC_W - 1);

    logic signed [PW-1:0]    base;
    logic signed [PW-1:0]    delta;
    logic signed [PW-1:0]    prod;
    logic signed [PW-1:0]    blend;
    logic [AMP_W-1:0]        mag_raw;
    logic [AMP_W-1:0]        mag;
    logic signed [OUT_W-1:0] smag;

    always_comb begin
        base    = $signed({2'b00, y_lo, {FRAC_W{1'b0}}});
        delta   = PW'($signed({1'b0, y_hi}) - $signed({1'b0, y_lo}));
        prod    = delta * $signed(PW'({1'b0, frac}));
        blend   = base + prod + HALF_LSB;
        mag_raw = blend[FRAC_W +: AMP_W];
    end

    if (GAIN_EN) begin : g_gain
        localparam int GBITS = 24;
        localparam int GW    = gain_word(IDX_W, GBITS);
        logic [63:0] scaled;
        logic [63:0] shifted;
        always_comb begin
            scaled  = 64'(mag_raw) * 64'(GW) + (64'(1) << (GBITS - 1));
            shifted = scaled >> GBITS;
            mag     = (shifted > 64'(FS)) ? AMP_W'(FS) : shifted[AMP_W-1:0];
        end
    end else begin : g_plain
        assign mag = mag_raw;
    end

    assign smag = $signed(OUT_W'(mag));

    always_ff @(posedge clk) begin
        if (rst) begin
            sample  <= '0;
            out_vld <= 1'b0;
        end else begin
            sample  <= neg ? -smag : smag;
            out_vld <= in_vld;
        end
    end
endmodule

// File: rtl/sine_dds.sv
module sine_dds #(
    parameter int ACC_W   = 32,
    parameter int IDX_W   = 10,
    parameter int FRAC_W  = 6,
    parameter int AMP_W   = 16,
    parameter int OUT_W   = 16,
    parameter bit GAIN_EN = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ce,
    input  logic [ACC_W-1:0]        ftw,
    output logic signed [OUT_W-1:0] sample,
    output logic                    sample_vld
);
    localparam int QA_W = IDX_W - 2;
    localparam int FS   = 2 ** (OUT_W - 1) - 1;

    logic [ACC_W-1:0]  phase;
    logic [QA_W:0]     f_lo;
    logic [QA_W:0]     f_hi;
    logic [FRAC_W-1:0] f_frac;
    logic              f_neg;
    logic              f_vld;
    logic [AMP_W-1:0]  t_lo;
    logic [AMP_W-1:0]  t_hi;
    logic [FRAC_W-1:0] t_frac;
    logic              t_neg;
    logic              t_vld;

    sdds_accum #(.ACC_W(ACC_W)) u_accum (
        .clk(clk), .rst(rst), .ce(ce), .ftw(ftw), .phase(phase)
    );

    sdds_fold #(.ACC_W(ACC_W), .IDX_W(IDX_W), .FRAC_W(FRAC_W)) u_fold (
        .clk(clk), .rst(rst), .in_vld(ce), .phase(phase),
        .lo_addr(f_lo), .hi_addr(f_hi), .frac(f_frac), .neg(f_neg), .out_vld(f_vld)
    );

    sdds_qtable #(.QA_W(QA_W), .AMP_W(AMP_W), .FS(FS), .FRAC_W(FRAC_W)) u_table (
        .clk(clk), .rst(rst), .in_vld(f_vld), .lo_addr(f_lo), .hi_addr(f_hi),
        .frac_in(f_frac), .neg_in(f_neg),
        .y_lo(t_lo), .y_hi(t_hi), .frac_out(t_frac), .neg_out(t_neg), .out_vld(t_vld)
    );

    sdds_lerp #(
        .AMP_W(AMP_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W), .IDX_W(IDX_W),
        .FS(FS), .GAIN_EN(GAIN_EN)
    ) u_lerp (
        .clk(clk), .rst(rst), .in_vld(t_vld), .y_lo(t_lo), .y_hi(t_hi),
        .frac(t_frac), .neg(t_neg), .sample(sample), .out_vld(sample_vld)
    );
endmodule

// File: rtl/sdds_checks.sv
module sdds_checks #(
    parameter int OUT_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    ce,
    input logic signed [OUT_W-1:0] sample,
    input logic                    sample_vld
);
    localparam logic signed [OUT_W-1:0] FS_P = OUT_W'(2 ** (OUT_W - 1) - 1);
    localparam logic signed [OUT_W-1:0] FS_N = -FS_P;

    logic [1:0] since_rst;
    logic       seen_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
            seen_vld  <= 1'b0;
        end else begin
            if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
            if (sample_vld) seen_vld <= 1'b1;
        end
    end

    AST_RESET_VLD: assert property (@(posedge clk) $past(rst) |-> !sample_vld); // R1

    AST_FIRST_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sample_vld && !seen_vld) |-> (sample == '0)); // R1

    AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (sample_vld == $past(ce, 3))); // R4

    AST_MAG_BOUND: assert property (@(posedge clk) disable iff (rst)
        sample_vld |-> (sample <= FS_P && sample >= FS_N)); // R9
endmodule

bind sine_dds sdds_checks #(.OUT_W(OUT_W)) u_checks (
    .clk(clk), .rst(rst), .ce(ce), .sample(sample), .sample_vld(sample_vld)
);

// File: tb/sine_dds_bench.sv
module sine_dds_bench;
    localparam int  CLK_NS = 10;
    localparam real FS_R   = 32767.0;
    localparam real TWO_PI = 6.28318530717958647692;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               ce  = 1'b0;
    logic [31:0]        ftw = '0;
    logic signed [15:0] sample;
    logic               sample_vld;

    int          n_checks = 0;
    int          n_fails  = 0;
    bit          finished = 1'b0;
    logic [31:0] mphase;
    logic [31:0] exp_q[$];
    logic [2:0]  ce_hist;
    bit          got;
    logic signed [15:0] got_s;
    logic [31:0] got_ph;

    always #(CLK_NS / 2) clk = ~clk;

    sine_dds u_sine_dds (
        .clk(clk), .rst(rst), .ce(ce), .ftw(ftw),
        .sample(sample), .sample_vld(sample_vld)
    );

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic real ref_val(logic [31:0] ph);
        return FS_R * $sin(TWO_PI * real'(ph[31:16]) / 65536.0);
    endfunction

    // One clock: drive ce, model the edge, sample at the falling edge.
    task automatic step(bit ce_v);
        ce = ce_v;
        @(posedge clk);
        ce_hist = {ce_hist[1:0], ce_v};
        if (ce_v) begin
            exp_q.push_back(mphase);
            mphase = mphase + ftw;
        end
        @(negedge clk);
        chk(sample_vld == ce_hist[2], "R4", "valid timing", longint'(sample_vld), longint'(ce_hist[2]));
        got = sample_vld && (exp_q.size() > 0);
        if (got) begin
            got_ph = exp_q.pop_front();
            got_s  = sample;
        end
    endtask

    task automatic check_near(string req);
        real r;
        real d;
        if (got) begin
            r = ref_val(got_ph);
            d = real'(got_s) - r;
            if (d < 0.0) d = -d;
            chk(d <= 2.0, req, "sine accuracy", longint'(got_s), longint'($rtoi(r + (r < 0.0 ? -0.5 : 0.5))));
            chk(got_s != 16'sh8000 && got_s <= 16'sd32767 && got_s >= -16'sd32767,
                "R9", "range", longint'(got_s), 32767);
        end
    endtask

    task automatic do_reset(logic [31:0] w);
        rst = 1'b1;
        ce  = 1'b0;
        ftw = w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst     = 1'b0;
        ce_hist = '0;
        mphase  = '0;
        exp_q.delete();
        chk(sample_vld == 1'b0, "R1", "valid low after reset", longint'(sample_vld), 0);
    endtask

    task automatic t_reset();
        do_reset(32'h0100_0000);
        for (int i = 0; i < 3; i++) step(1'b1);
        chk(got, "R1", "first sample present", longint'(got), 1);
        chk(got_s == 0, "R1", "first sample value", longint'(got_s), 0);
    endtask

    task automatic t_quarter();
        logic signed [15:0] e;
        do_reset(32'h4000_0000);
        for (int i = 0; i < 14; i++) begin
            step(1'b1);
            if (got) begin
                case (got_ph[31:30])
                    2'd0: e = 16'sd0;
                    2'd1: e = 16'sd32767;
                    2'd2: e = 16'sd0;
                    default: e = -16'sd32767;
                endcase
                chk(got_s == e, "R6", "quadrant point", longint'(got_s), longint'(e));
            end
        end
    endtask

    task automatic t_accuracy();
        do_reset(32'h0123_4567);
        for (int i = 0; i < 400; i++) begin
            step(1'b1);
            check_near("R5");
        end
    endtask

    task automatic t_period();
        logic signed [15:0] buf_s [0:127];
        int n;
        n = 0;
        do_reset(32'h0400_0000);
        for (int i = 0; i < 131; i++) begin
            step(1'b1);
            check_near("R7");
            if (got && n < 128) begin
                buf_s[n] = got_s;
                n++;
            end
        end
        chk(n == 128, "R7", "sample count", longint'(n), 128);
        for (int k = 0; k < 64; k++)
            chk(buf_s[k] == buf_s[k + 64], "R7", "period repeat",
                longint'(buf_s[k + 64]), longint'(buf_s[k]));
    endtask

    task automatic t_gaps();
        do_reset(32'h0200_0000);
        for (int i = 0; i < 200; i++) begin
            step(((i % 5) != 2) && ((i % 7) != 0));
            check_near("R3");
        end
        for (int i = 0; i < 4; i++) step(1'b0);
        chk(sample_vld == 1'b0, "R3", "valid low in gap", longint'(sample_vld), 0);
    endtask

    task automatic t_retune();
        do_reset(32'h0050_0000);
        for (int i = 0; i < 60; i++) begin
            step(1'b1);
            check_near("R8");
        end
        ftw = 32'h0333_3333;
        for (int i = 0; i < 60; i++) begin
            step(1'b1);
            check_near("R8");
        end
        ftw = 32'h0000_1000;
        for (int i = 0; i < 30; i++) begin
            step(1'b1);
            check_near("R8");
        end
    endtask

    task automatic t_wrap();
        do_reset(32'hFC00_0000);
        for (int i = 0; i < 80; i++) begin
            step(1'b1);
            check_near("R2");
        end
        ftw = 32'hFFFF_F000;
        for (int i = 0; i < 40; i++) begin
            step(1'b1);
            check_near("R2");
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_quarter();
        t_accuracy();
        t_period();
        t_gaps();
        t_retune();
        t_wrap();
        finish_run();
    end

    initial begin
        #(CLK_NS * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule